// File: doc/BRIEF.md
# Early-Prompt-Late Spreading Code Generator

This block makes three local replicas of a 1023-chip spreading code, one chip per sample clock, for the early, prompt and late correlators of a code tracking loop. Each replica has its own phase accumulator. The accumulator adds an increment word every running cycle, and its carry-out is a one-cycle chip-advance pulse. That pulse steps a chip address counter, which wraps from 1022 to 0. The counter value addresses a code table. Each word of the table holds one chip of each of 32 codes, and a code-select input picks one bit of the word.

The loop-filter correction is a signed value. It is added to the nominal increment that gives a 1.023 MHz chip rate from a 6.25 MHz sample clock. After reset the generator waits for a block-ready pulse. On that pulse each counter loads its own starting chip. The early and late accumulators are also preset to half full, which puts each of them half a chip away from prompt. After the first load, block-ready has no further effect until the next reset. A pause input freezes all three replicas. A small computed test table stands in for the real code contents.

Top module: `epl_code_gen`

## Requirements
- R1: After a synchronous active-high reset, all counters and accumulators are zero and the generator does not advance until block-ready. The three chips therefore show the table bit at address 0.
- R2: The increment is 703000247 plus the sign-extended 16-bit correction, modulo 2^32. In every running cycle each accumulator adds the increment modulo 2^32. A carry out of bit 31 is a chip pulse that lasts one cycle.
- R3: A chip pulse advances its counter by one. From 1022 the counter goes to 0, and it never holds a value above 1022.
- R4: The first block-ready after reset loads each counter with its own offset input. An offset above 1022 loads 0. The same pulse sets the prompt accumulator to 0 and the early and late accumulators to 2^31. Running starts in the next cycle.
- R5: A block-ready that arrives after the first load has no effect.
- R6: While pause is high, no accumulator and no counter changes.
- R7: Each chip output is bit `code_sel` of the table word at that replica's address. Bit k of the word at address a is a[k mod 10] XOR a[(7k+3) mod 10] XOR (k mod 3 == 0).
- R8: When the offsets are p for early, p for prompt and p−1 (mod 1023) for late, early leads prompt by half a chip and late trails prompt by half a chip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_rdy | input | 1 | Block-ready pulse; the first one after reset loads the start state |
| pause | input | 1 | Freezes all replicas while high |
| corr | input | 16 | Signed loop-filter correction added to the nominal increment |
| code_sel | input | 5 | Selects which of the 32 codes is output |
| off_early | input | 10 | Starting chip of the early replica |
| off_prompt | input | 10 | Starting chip of the prompt replica |
| off_late | input | 10 | Starting chip of the late replica |
| chip_early | output | 1 | Early code chip |
| chip_prompt | output | 1 | Prompt code chip |
| chip_late | output | 1 | Late code chip |

## Verification
The bench keeps its own cycle model of the three accumulators and counters. It compares every chip in every cycle against that model, both while random corrections, pauses, code changes and block-ready pulses are applied and during directed segments.

The directed segments target these failures:
- A start at offset 1022 catches a counter that fails to wrap and runs to 1023.
- A hold between reset and block-ready catches a generator that starts too early.
- A block-ready in the middle of a run catches a reload that moves the code phase.
- A long pause catches an accumulator that still creeps forward.

Because the increment is checked against the computed nominal value, a wrong half-fill preset or a dropped correction sign bit makes the early and late replicas change chip in the wrong cycles.

// File: rtl/epl_code_pkg.sv
package epl_code_pkg;

    localparam int ACC_W      = 32;
    localparam int CHIP_COUNT = 1023;
    localparam int ADDR_W     = $clog2(CHIP_COUNT);
    localparam int NUM_CODES  = 32;
    localparam int SEL_W      = $clog2(NUM_CODES);
    localparam int CORR_W     = 16;
    localparam int NUM_REP    = 3;

    // round(1.023e6 / 6.25e6 * 2^32)
    localparam logic [ACC_W-1:0] NOMINAL_INC = 32'd703000247;

    typedef enum logic [1:0] {
        REP_EARLY  = 2'd0,
        REP_PROMPT = 2'd1,
        REP_LATE   = 2'd2
    } replica_e;

    typedef struct packed {
        logic load;   // take start state
        logic half;   // preset accumulator half full on load
        logic run;    // accumulate this cycle
    } dds_ctl_t;

    // Test code table: one chip of each code per word.
    function automatic logic [NUM_CODES-1:0] code_word(input logic [ADDR_W-1:0] a);
        logic [NUM_CODES-1:0] w;
        for (int k = 0; k < NUM_CODES; k++) begin
            w[k] = a[k % ADDR_W] ^ a[(7 * k + 3) % ADDR_W] ^ ((k % 3) == 0);
        end
        return w;
    endfunction

endpackage

// File: rtl/epl_pulse_dds.sv
module epl_pulse_dds
    import epl_code_pkg::*;
#(
    parameter int W = ACC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  dds_ctl_t     ctl,
    input  logic [W-1:0] inc,
    output logic         pulse
);
    localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] acc;
    logic [W:0]   sum;

    assign sum   = {1'b0, acc} + {1'b0, inc};
    assign pulse = ctl.run & sum[W];

    always_ff @(posedge clk) begin
        if (rst)           acc <= '0;
        else if (ctl.load) acc <= ctl.half ? HALF : '0;
        else if (ctl.run)  acc <= sum[W-1:0];
    end

    AST_ACC_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!ctl.load && !ctl.run) |=> $stable(acc)); // R6

    AST_HALF_PRESET: assert property (@(posedge clk) disable iff (rst)
        (ctl.load && ctl.half) |=> (acc == HALF)); // R4

    AST_ACC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (ctl.run && !ctl.load) |=> (acc == W'($past(acc) + $past(inc)))); // R2
endmodule

// File: rtl/epl_chip_counter.sv
module epl_chip_counter #(
    parameter int AW   = 10,
    parameter int LAST = 1022
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] offset,
    input  logic          step,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] LAST_V = AW'(LAST);

    always_ff @(posedge clk) begin
        if (rst)       addr <= '0;
        else if (load) addr <= (offset > LAST_V) ? '0 : offset;
        else if (step) addr <= (addr == LAST_V) ? '0 : addr + 1'b1;
    end

    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
        addr <= LAST_V); // R3

    AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (step && !load && addr == LAST_V) |=> (addr == '0)); // R3

    AST_ADDR_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!step && !load) |=> $stable(addr)); // R6
endmodule

// File: rtl/epl_code_table.sv
module epl_code_table
    import epl_code_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [SEL_W-1:0]  sel,
    output logic              chip
);
    logic [NUM_CODES-1:0] word;

    assign word = code_word(addr);
    assign chip = word[sel];
endmodule

// File: rtl/epl_code_gen.sv
module epl_code_gen
    import epl_code_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     blk_rdy,
    input  logic                     pause,
    input  logic signed [CORR_W-1:0] corr,
    input  logic [SEL_W-1:0]         code_sel,
    input  logic [ADDR_W-1:0]        off_early,
    input  logic [ADDR_W-1:0]        off_prompt,
    input  logic [ADDR_W-1:0]        off_late,
    output logic                     chip_early,
    output logic                     chip_prompt,
    output logic                     chip_late
);
    logic                armed;      // waiting for first block-ready
    logic                load;
    logic [ACC_W-1:0]    inc;
    logic [ADDR_W-1:0]   offs  [NUM_REP];
    logic [NUM_REP-1:0]  pulses;
    logic [NUM_REP-1:0]  chips;

    assign load = armed & blk_rdy;
    assign inc  = NOMINAL_INC + {{(ACC_W-CORR_W){corr[CORR_W-1]}}, corr};

    assign offs[REP_EARLY]  = off_early;
    assign offs[REP_PROMPT] = off_prompt;
    assign offs[REP_LATE]   = off_late;

    always_ff @(posedge clk) begin
        if (rst)       armed <= 1'b1;
        else if (load) armed <= 1'b0;
    end

    for (genvar r = 0; r < NUM_REP; r++) begin : g_rep
        dds_ctl_t          ctl;
        logic [ADDR_W-1:0] addr;

        assign ctl.load = load;
        assign ctl.half = (r != int'(REP_PROMPT));
        assign ctl.run  = !armed && !pause;

        epl_pulse_dds #(.W(ACC_W)) u_dds (
            .clk  (clk),
            .rst  (rst),
            .ctl  (ctl),
            .inc  (inc),
            .pulse(pulses[r])
        );

        epl_chip_counter #(.AW(ADDR_W), .LAST(CHIP_COUNT-1)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .load  (load),
            .offset(offs[r]),
            .step  (pulses[r]),
            .addr  (addr)
        );

        epl_code_table u_tab (
            .addr(addr),
            .sel (code_sel),
            .chip(chips[r])
        );
    end

    assign chip_early  = chips[REP_EARLY];
    assign chip_prompt = chips[REP_PROMPT];
    assign chip_late   = chips[REP_LATE];

    AST_ARM_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (armed && blk_rdy) |=> !armed); // R4

    AST_ARM_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> armed); // R1

    AST_NO_PULSE_WHEN_PAUSED: assert property (@(posedge clk) disable iff (rst)
        (pause || armed) |-> (pulses == '0)); // R6

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (pulses[REP_PROMPT] && !load) |=> !pulses[REP_PROMPT]); // R2
endmodule

// File: tb/epl_code_gen_test.sv
module epl_code_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        blk_rdy = 1'b0;
    logic        pause = 1'b0;
    logic [15:0] corr = '0;
    logic [4:0]  code_sel = '0;
    logic [9:0]  off_e = '0, off_p = '0, off_l = '0;
    logic        chip_e, chip_p, chip_l;

    int checks = 0;
    int errors = 0;

    // model state
    logic [31:0] m_acc  [3];
    logic [9:0]  m_addr [3];
    logic        m_armed;

    always #5 clk = ~clk;

    epl_code_gen uut (
        .clk(clk), .rst(rst), .blk_rdy(blk_rdy), .pause(pause),
        .corr(corr), .code_sel(code_sel),
        .off_early(off_e), .off_prompt(off_p), .off_late(off_l),
        .chip_early(chip_e), .chip_prompt(chip_p), .chip_late(chip_l)
    );

    function automatic logic tb_bit(input logic [9:0] a, input int k);
        return a[k % 10] ^ a[(7 * k + 3) % 10] ^ ((k % 3) == 0);
    endfunction

    function automatic logic [9:0] clampoff(input logic [9:0] o);
        return (o > 10'd1022) ? 10'd0 : o;
    endfunction

    // Advance the model by the edge about to come, using present inputs.
    task automatic model_step();
        logic [31:0] inc;
        logic [32:0] s;
        inc = 32'd703000247 + {{16{corr[15]}}, corr};
        if (rst) begin
            m_armed = 1'b1;
            for (int r = 0; r < 3; r++) begin m_acc[r] = '0; m_addr[r] = '0; end
        end else if (m_armed && blk_rdy) begin
            m_armed   = 1'b0;
            m_acc[0]  = 32'h8000_0000;
            m_acc[1]  = '0;
            m_acc[2]  = 32'h8000_0000;
            m_addr[0] = clampoff(off_e);
            m_addr[1] = clampoff(off_p);
            m_addr[2] = clampoff(off_l);
        end else if (!m_armed && !pause) begin
            for (int r = 0; r < 3; r++) begin
                s = {1'b0, m_acc[r]} + {1'b0, inc};
                m_acc[r] = s[31:0];
                if (s[32]) m_addr[r] = (m_addr[r] == 10'd1022) ? 10'd0 : m_addr[r] + 10'd1;
            end
        end
    endtask

    task automatic check_one(input string tag, input string nm, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %b expected %b at %0t", tag, nm, got, exp, $time);
        end
    endtask

    task automatic cycle(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_one(tag, "early",  chip_e, tb_bit(m_addr[0], int'(code_sel)));
        check_one(tag, "prompt", chip_p, tb_bit(m_addr[1], int'(code_sel)));
        check_one(tag, "late",   chip_l, tb_bit(m_addr[2], int'(code_sel)));
    endtask

    task automatic set_offsets(input logic [9:0] p);
        off_e = p;
        off_p = p;
        off_l = (p == 10'd0) ? 10'd1022 : p - 10'd1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);

        // R1: reset state and hold before block-ready
        set_offsets(10'd1022);
        code_sel = 5'd3;
        rst = 1'b1;
        cycle("R1 reset");
        cycle("R1 reset");
        rst = 1'b0;
        for (int i = 0; i < 6; i++) cycle("R1 waiting");
        code_sel = 5'd0;
        cycle("R1 R7 waiting sel0");

        // R4 load, then R3 wrap from 1022
        blk_rdy = 1'b1;
        cycle("R4 load");
        blk_rdy = 1'b0;
        for (int i = 0; i < 60; i++) cycle("R3 R8 wrap");

        // R6 pause
        pause = 1'b1;
        for (int i = 0; i < 25; i++) cycle("R6 paused");
        pause = 1'b0;
        for (int i = 0; i < 10; i++) cycle("R6 resumed");

        // R5: late block-ready with new offsets must not reload
        set_offsets(10'd500);
        blk_rdy = 1'b1;
        cycle("R5 ignored");
        blk_rdy = 1'b0;
        for (int i = 0; i < 30; i++) cycle("R5 after");

        // R8 spacing from a fresh start, and out-of-range offset (R4)
        rst = 1'b1; cycle("R1 reset2"); rst = 1'b0;
        set_offsets(10'd100);
        off_e = 10'd1023;
        code_sel = 5'd7;
        blk_rdy = 1'b1; cycle("R4 clamp load"); blk_rdy = 1'b0;
        for (int i = 0; i < 40; i++) cycle("R4 R8 spacing");

        // R2 negative correction extreme
        corr = 16'h8000;
        for (int i = 0; i < 40; i++) cycle("R2 neg corr");
        corr = 16'h7fff;
        for (int i = 0; i < 40; i++) cycle("R2 pos corr");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            int v;
            v = int'($urandom_range(0, 8000)) - 4000;
            corr = 16'(v);
            pause = ($urandom_range(0, 99) < 15);
            if ($urandom_range(0, 99) < 3) code_sel = 5'($urandom_range(0, 31));
            blk_rdy = ($urandom_range(0, 99) < 2);
            rst = ($urandom_range(0, 199) == 0);
            if (rst) set_offsets(10'($urandom_range(0, 1022)));
            cycle("R2 R5 R6 R7 R8 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule